// File: doc/BRIEF.md
# Cache-Program Engine with Status Byte

This block models the program path on the device side of a paged flash memory. It holds two page buffers in a pipeline. The cache buffer takes in the next page's data while the data buffer's page is being programmed. Decoded commands arrive on a small command port:

- a plain program confirm,
- a cached program confirm,
- a status read,
- a reset.

A write-protect level is sampled live. The time to move data between the buffers and the time of the internal program are both counted in clock cycles, and both counts are parameters. A fail result can be forced for each page through a test input.

The block drives a status byte and a ready/busy output. The status byte reports several things:

- whether the cache buffer is free,
- whether the internal controller is idle,
- the pass/fail result of the page just programmed,
- the pass/fail result of the page before it.

A cached confirm returns ready as soon as the cache buffer is free again. A plain confirm, used for the last page of a run, holds ready low until every program in flight has finished.

Top module: `cache_program_engine`

## Requirements
- R1: After reset the status byte reads E0h with write protect released, and ready_busy is 1.
- R2: Status bit 7 follows the wp_n input in the same cycle (0 = protected). Any confirm given while wp_n is 0 is ignored.
- R3: A confirm is ignored if no load_stb was accepted since the previous accepted confirm or reset. A status-read command (cmd_op 2) changes no state.
- R4: An accepted cached confirm (cmd_op 1) with the controller idle sets bit 6 to 0 for exactly XFER_CYC cycles. Bit 6 then returns to 1 while bit 5 stays 0 for a further PROG_CYC cycles.
- R5: A buffer transfer starts only after the earlier internal program has finished. Bit 6 stays 0 until that program has finished and XFER_CYC more cycles have passed.
- R6: Bit 0 takes the fail result of the page being programmed when its program ends (1 = fail, 0 = pass). When the next page's program starts, bit 1 takes the old bit 0 and bit 0 clears.
- R7: An accepted plain confirm (cmd_op 0) holds bit 6 at 0 until its own page's program has finished. This includes any program that was still pending ahead of it.
- R8: While bit 6 is 0, confirms and load_stb are ignored.
- R9: A reset command (cmd_op 3) aborts all activity. The next cycle shows bits 6 and 5 at 1 and bits 1 and 0 at 0.
- R10: A page's fail result is the value of fail_inject in the cycle that its program starts, which is the last cycle of its transfer.
- R11: ready_busy equals status bit 6 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 plain confirm, 1 cached confirm, 2 status read, 3 reset |
| load_stb | input | 1 | Page data has been written into the cache buffer |
| wp_n | input | 1 | Write protect, low = protected |
| fail_inject | input | 1 | Fail result for the page whose program starts this cycle |
| status | output | 8 | {wp, cache free, idle, 000, previous fail, current fail} |
| ready_busy | output | 1 | 1 = ready for the next page |

## Verification
Two events can land on the same clock edge: the end of a running program and the acceptance of a new confirm. The queued transfer must then start counting from that edge, and the final-page flag must not be lost. The bench steers into this case by watching its own timeline model and issuing a confirm exactly on the completion edge. Random traffic adds cases where a transfer is waiting when a program finishes. Status bit 1 and bit 6 are compared every cycle against a model that works from edge timestamps.

// File: rtl/cpe_pkg.sv
package cpe_pkg;
  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_CACHE = 2'd1,
    OP_STAT  = 2'd2,
    OP_RESET = 2'd3
  } cpe_op_e;

  localparam int ST_WP   = 7;
  localparam int ST_FREE = 6;
  localparam int ST_IDLE = 5;

  function automatic logic [7:0] pack_status(input logic wp, input logic free,
                                             input logic idle, input logic prev_f,
                                             input logic cur_f);
    pack_status = {wp, free, idle, 3'b000, prev_f, cur_f};
  endfunction

  function automatic int cnt_width(input int n);
    cnt_width = (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cpe_xfer.sv
module cpe_xfer #(
  parameter int XFER_CYC = 375
) (
  input  logic clk,
  input  logic rst_n,
  input  logic abort,
  input  logic start,
  input  logic prog_busy,
  output logic pending,
  output logic done
);
  localparam int CW = cpe_pkg::cnt_width(XFER_CYC);
  localparam logic [CW-1:0] LAST = CW'(XFER_CYC - 1);

  logic [CW-1:0] cnt;

  // R5: counting is held off while an earlier program runs
  assign done = pending && !prog_busy && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      cnt     <= '0;
    end else if (abort) begin
      pending <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      pending <= 1'b1;
      cnt     <= '0;
    end else if (done) begin
      pending <= 1'b0;
      cnt     <= '0;
    end else if (pending && !prog_busy) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cpe_prog_timer.sv
module cpe_prog_timer #(
  parameter int PROG_CYC = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic abort,
  input  logic start,
  input  logic fail_in,
  output logic active,
  output logic done,
  output logic fail_q
);
  localparam int PW = cpe_pkg::cnt_width(PROG_CYC);

  logic [PW-1:0] remain;

  assign done = active && (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      remain <= '0;
      fail_q <= 1'b0;
    end else if (abort) begin
      active <= 1'b0;
      remain <= '0;
      fail_q <= 1'b0;
    end else if (start) begin
      // R10: fail result captured when the page's program begins
      active <= 1'b1;
      remain <= PW'(PROG_CYC - 1);
      fail_q <= fail_in;
    end else if (done) begin
      active <= 1'b0;
    end else if (active) begin
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/cpe_result.sv
module cpe_result (
  input  logic clk,
  input  logic rst_n,
  input  logic abort,
  input  logic prog_start,
  input  logic prog_done,
  input  logic page_fail,
  output logic cur_fail,
  output logic prev_fail
);
  // R6: two-stage pass/fail history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_fail  <= 1'b0;
      prev_fail <= 1'b0;
    end else if (abort) begin
      cur_fail  <= 1'b0;
      prev_fail <= 1'b0;
    end else if (prog_start) begin
      prev_fail <= cur_fail;
      cur_fail  <= 1'b0;
    end else if (prog_done) begin
      cur_fail <= page_fail;
    end
  end
endmodule

// File: rtl/cache_program_engine.sv
module cache_program_engine #(
  parameter int XFER_CYC = 375,
  parameter int PROG_CYC = 25000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       load_stb,
  input  logic       wp_n,
  input  logic       fail_inject,
  output logic [7:0] status,
  output logic       ready_busy
);
  import cpe_pkg::*;

  logic xfer_pending, xfer_done;
  logic prog_active, prog_done, page_fail;
  logic cur_fail, prev_fail;
  logic final_wait, loaded;
  logic cache_free, ctl_idle;
  logic is_confirm, is_plain, accept, abort;

  assign is_confirm = cmd_valid && ((cmd_op == OP_PROG) || (cmd_op == OP_CACHE));
  assign is_plain   = (cmd_op == OP_PROG);
  // R2 R3 R8: every condition must hold to take a confirm
  assign accept     = is_confirm && cache_free && wp_n && loaded;
  // R9
  assign abort      = cmd_valid && (cmd_op == OP_RESET);

  // R4 R7
  assign cache_free = !xfer_pending && !final_wait;
  assign ctl_idle   = !prog_active && !xfer_pending;

  cpe_xfer #(.XFER_CYC(XFER_CYC)) u_xfer (
    .clk(clk), .rst_n(rst_n), .abort(abort), .start(accept),
    .prog_busy(prog_active), .pending(xfer_pending), .done(xfer_done)
  );

  cpe_prog_timer #(.PROG_CYC(PROG_CYC)) u_prog (
    .clk(clk), .rst_n(rst_n), .abort(abort), .start(xfer_done),
    .fail_in(fail_inject), .active(prog_active), .done(prog_done),
    .fail_q(page_fail)
  );

  cpe_result u_res (
    .clk(clk), .rst_n(rst_n), .abort(abort), .prog_start(xfer_done),
    .prog_done(prog_done), .page_fail(page_fail),
    .cur_fail(cur_fail), .prev_fail(prev_fail)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      final_wait <= 1'b0;
      loaded     <= 1'b0;
    end else if (abort) begin
      final_wait <= 1'b0;
      loaded     <= 1'b0;
    end else begin
      if (accept) begin
        final_wait <= is_plain;
      end else if (prog_done && !xfer_pending) begin
        final_wait <= 1'b0;
      end
      if (accept) begin
        loaded <= 1'b0;
      end else if (load_stb && cache_free) begin
        loaded <= 1'b1;
      end
    end
  end

  // R1 R11
  assign status     = pack_status(wp_n, cache_free, ctl_idle, prev_fail, cur_fail);
  assign ready_busy = cache_free;
endmodule

// File: rtl/cpe_checker.sv
module cpe_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       wp_n,
  input logic [7:0] status,
  input logic       ready_busy,
  input logic       xfer_pending,
  input logic       xfer_done,
  input logic       prog_active,
  input logic       loaded
);
  // R5
  xfer_after_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !prog_active);

  // R4
  busy_cache_implies_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status[6] |-> !status[5]);

  // R9
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd3) |=> (status[6:5] == 2'b11 && status[1:0] == 2'b00));

  // R3
  empty_confirm_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op[1] == 1'b0 && !loaded && status[6]) |=> status[6]);

  // R2
  wp_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] == wp_n);

  // R11
  pending_means_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_pending |-> !ready_busy);
endmodule

bind cache_program_engine cpe_checker u_cpe_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .wp_n(wp_n), .status(status), .ready_busy(ready_busy),
  .xfer_pending(xfer_pending), .xfer_done(xfer_done),
  .prog_active(prog_active), .loaded(loaded)
);

// File: tb/cache_program_engine_test.sv
module cache_program_engine_test;
  localparam int XF = 3;
  localparam int PG = 10;
  localparam time TCK = 8ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd2;
  logic load_stb = 1'b0;
  logic wp_n = 1'b1;
  logic fail_inject = 1'b0;
  logic [7:0] status;
  logic ready_busy;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  always #(TCK/2) clk = ~clk;

  cache_program_engine #(.XFER_CYC(XF), .PROG_CYC(PG)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .load_stb(load_stb), .wp_n(wp_n), .fail_inject(fail_inject),
    .status(status), .ready_busy(ready_busy)
  );

  // timeline model: events kept as edge timestamps
  int n = 0;
  bit m_xp, m_pa, m_fin, m_ld, m_s0, m_s1, m_cf;
  int m_xt, m_pt;

  function automatic logic [7:0] exp_status(input bit wp);
    bit free = !m_xp && !m_fin;
    bit idle = !m_pa && !m_xp;
    return {wp, free, idle, 3'b000, m_s1, m_s0};
  endfunction

  task automatic model_clear();
    m_xp = 0; m_pa = 0; m_fin = 0; m_ld = 0; m_s0 = 0; m_s1 = 0; m_cf = 0;
    m_xt = 0; m_pt = 0;
  endtask

  task automatic model_edge(input bit v, input bit [1:0] op, input bit ld,
                            input bit wp, input bit fl);
    bit free_pre, acc;
    n++;
    if (v && op == 2'd3) begin model_clear(); return; end
    free_pre = !m_xp && !m_fin;
    acc = v && !op[1] && free_pre && wp && m_ld;
    if (m_pa && n == m_pt) begin
      m_pa = 0; m_s0 = m_cf;
      if (!m_xp) m_fin = 0;
    end
    if (m_xp && n == m_xt) begin
      m_xp = 0; m_s1 = m_s0; m_s0 = 0; m_cf = fl; m_pa = 1; m_pt = n + PG;
    end
    if (acc) begin
      m_xp = 1;
      m_xt = (m_pa ? m_pt : n) + XF;
      m_fin = (op == 2'd0);
      m_ld = 0;
    end else if (ld && free_pre) begin
      m_ld = 1;
    end
  endtask

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h at edge %0d", tag, got, exp, n);
    end
  endtask

  task automatic compare();
    logic [7:0] e;
    e = exp_status(wp_n);
    check("R2 wp bit", {7'd0, status[7]}, {7'd0, e[7]});
    check("R4 R5 R7 R8 cache-free bit", {7'd0, status[6]}, {7'd0, e[6]});
    check("R4 idle bit", {7'd0, status[5]}, {7'd0, e[5]});
    check("R6 R10 fail bits", {6'd0, status[1:0]}, {6'd0, e[1:0]});
    check("R11 ready_busy", {7'd0, ready_busy}, {7'd0, e[6]});
  endtask

  task automatic cyc(input bit v, input bit [1:0] op, input bit ld,
                     input bit wp, input bit fl);
    @(negedge clk);
    compare();
    cmd_valid = v; cmd_op = op; load_stb = ld; wp_n = wp; fail_inject = fl;
    @(posedge clk);
    model_edge(v, op, ld, wp, fl);
  endtask

  task automatic idle(input int k, input bit fl);
    for (int i = 0; i < k; i++) cyc(0, 2'd2, 0, 1, fl);
  endtask

  initial begin
    #(TCK * 150000);
    if (!finished) begin
      fails++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 status after reset", status, 8'hE0);
    check("R1 ready after reset", {7'd0, ready_busy}, 8'd1);

    // R3 confirm with nothing loaded, and a status read
    cyc(1, 2'd1, 0, 1, 0);
    cyc(1, 2'd2, 0, 1, 0);
    idle(2, 0);
    // R2 loaded but protected
    cyc(0, 2'd2, 1, 1, 0);
    cyc(1, 2'd1, 0, 0, 0);
    idle(2, 0);
    // R4 cached page, pass; R8 load while busy ignored
    cyc(1, 2'd1, 0, 1, 0);
    cyc(0, 2'd2, 1, 1, 0);
    idle(XF, 1);
    // R5 second cached page queued behind running program, R10 fail sampled
    cyc(0, 2'd2, 1, 1, 0);
    cyc(1, 2'd1, 0, 1, 1);
    while (m_xp) cyc(0, 2'd2, 0, 1, 1);
    idle(2, 0);
    // same-edge case: confirm lands on program completion edge
    cyc(0, 2'd2, 1, 1, 0);
    while (!(m_pa && m_pt == n + 1)) cyc(0, 2'd2, 0, 1, 0);
    cyc(1, 2'd0, 0, 1, 0);
    // R7 plain confirm holds ready until own program ends
    while (!exp_status(1'b1)[6]) cyc(0, 2'd2, 0, 1, 0);
    idle(2, 0);
    // R9 reset mid-program
    cyc(0, 2'd2, 1, 1, 0);
    cyc(1, 2'd1, 0, 1, 0);
    idle(XF + 2, 1);
    cyc(1, 2'd3, 0, 1, 0);
    idle(2, 0);
    // R2 reset with protect low gives 60h
    cyc(1, 2'd3, 0, 0, 0);
    @(negedge clk);
    check("R2 R9 status after reset, protected", status, 8'h60);
    cmd_valid = 0; wp_n = 1;
    @(posedge clk);
    model_edge(0, 2'd2, 0, 1, 0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit v, ld, wp, fl;
      bit [1:0] op;
      v  = ($urandom % 100) < 25;
      op = 2'($urandom % 4);
      if (op == 2'd3 && ($urandom % 8) != 0) op = 2'd1;
      ld = ($urandom % 100) < 30;
      wp = ($urandom % 100) < 92;
      fl = ($urandom % 100) < 35;
      cyc(v, op, ld, wp, fl);
    end
    @(negedge clk);
    compare();

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule